// File: doc/BRIEF.md
# Predicated Byte Load-Broadcast Unit

This execution unit carries out a vector load that fetches a single signed byte and copies it into every lane of a fixed-length vector. A start pulse supplies the operands: a base register index, a general-register value, a stack-pointer value, a 6-bit unsigned byte offset, an element-width selector and a byte-granular predicate. The unit forms the address, sends one single-byte read on a request/response memory port, sign-extends the returned byte to the selected element width and writes it into each active lane. Inactive lanes are written with zeros.

The predicate decides whether memory is touched at all. If no lane is active, no read is issued and the result is zero. A base index of 31 selects the stack pointer. A stack pointer with nonzero low four bits raises a fault in place of the read. For an instruction with no active lane, a configuration input chooses whether the stack-pointer check is still applied. A one-cycle `done` pulse marks the registered result.

Top module: `bcast_ld_unit`

## Requirements
- R1: The read address is the selected base plus the zero-extended 6-bit offset, modulo 2^64. The base is `sp_val` when `base_idx` is 31 and `gpr_val` otherwise.
- R2: `esize_sel` encodes the element width: 0 selects 16 bits, 1 selects 32 bits, and 2 or 3 select 64 bits. Lane e covers result bits [e*W +: W] for width W. Lane e is active when predicate bit e*W/8 is 1.
- R3: On completion after a read, every active lane holds the returned byte sign-extended to the element width.
- R4: Every inactive lane of the result is all zeros. Predicate bits other than the first bit of each lane have no effect.
- R5: With no active lane and no stack-pointer fault, no read request is raised. `done` is high one cycle after start, with an all-zero result and `sp_fault` low.
- R6: With at least one active lane, a base index of 31 and `sp_val[3:0]` nonzero, no read request is raised. `done` and `sp_fault` are high one cycle after start and the result is zero.
- R7: With no active lane and a base index of 31, a misaligned stack pointer faults when `sp_chk_idle` is 1 and does not fault when it is 0. An aligned stack pointer never faults.
- R8: `mem_req_valid` rises one cycle after start. It stays high with a constant `mem_req_addr` until the cycle in which `mem_req_ready` is high, and it is low afterwards.
- R9: `done` is high for exactly one cycle, one cycle after the cycle in which `mem_rsp_valid` is high. While `idle` is low, `start` is ignored and the operation in flight keeps its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted while `idle` is high |
| idle | output | 1 | Unit can accept `start` |
| base_idx | input | 5 | Base register index; 31 selects the stack pointer |
| gpr_val | input | 64 | General-register base value |
| sp_val | input | 64 | Stack-pointer base value |
| imm_off | input | 6 | Unsigned byte offset |
| esize_sel | input | 2 | Element width selector |
| pred | input | VLEN/8 | Predicate, one bit per vector byte |
| sp_chk_idle | input | 1 | Apply the stack-pointer check when no lane is active |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Returned byte |
| done | output | 1 | Result valid pulse |
| result | output | VLEN | Broadcast vector |
| sp_fault | output | 1 | Stack-pointer alignment fault, valid with `done` |

## Verification
The hardest case to reach is a predicate whose only set bits lie inside a lane rather than at its first byte. Such a mask must skip memory for wide elements but not for narrow ones. The bench therefore sweeps all 256 masks of a 64-bit vector against every width code. It derives each lane's activity and sign-extended value arithmetically, and it varies the acceptance and response delays. A start pulse with a different mask while a read is outstanding checks that the operands in flight are not disturbed.

// File: rtl/bcast_ld_pkg.sv
package bcast_ld_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ld_state_e;

  localparam int CHUNK_W    = 16;
  localparam int ADDR_W     = 64;
  localparam int SP_IDX     = 31;
  localparam int ALIGN_BITS = 4;
endpackage

// File: rtl/bcast_lane_mask.sv
// Maps the byte predicate to per-16-bit-chunk activity for the chosen width.
module bcast_lane_mask #(
  parameter int VLEN = 256
) (
  input  logic [1:0]           esize_sel,
  input  logic [VLEN/8-1:0]    pred,
  output logic [VLEN/16-1:0]   chunk_act,
  output logic [VLEN/16-1:0]   chunk_low,
  output logic                 any_act
);
  localparam int NCH = VLEN / 16;

  for (genvar j = 0; j < NCH; j++) begin : g_chunk
    localparam int PB16 = 2 * j;
    localparam int PB32 = (j / 2) * 4;
    localparam int PB64 = (j / 4) * 8;
    always_comb begin
      case (esize_sel)
        2'd0: begin
          chunk_act[j] = pred[PB16];
          chunk_low[j] = 1'b1;
        end
        2'd1: begin
          chunk_act[j] = pred[PB32];
          chunk_low[j] = ((j % 2) == 0);
        end
        default: begin
          chunk_act[j] = pred[PB64];
          chunk_low[j] = ((j % 4) == 0);
        end
      endcase
    end
  end

  assign any_act = |chunk_act;
endmodule

// File: rtl/bcast_fill.sv
// Builds the broadcast vector from a byte and chunk activity flags.
module bcast_fill #(
  parameter int VLEN = 256
) (
  input  logic [7:0]          ld_byte,
  input  logic [VLEN/16-1:0]  chunk_act,
  input  logic [VLEN/16-1:0]  chunk_low,
  output logic [VLEN-1:0]     vec
);
  localparam int NCH = VLEN / 16;

  for (genvar j = 0; j < NCH; j++) begin : g_chunk
    always_comb begin
      if (!chunk_act[j])
        vec[16*j +: 16] = '0;
      else if (chunk_low[j])
        vec[16*j +: 16] = {{8{ld_byte[7]}}, ld_byte};
      else
        vec[16*j +: 16] = {16{ld_byte[7]}};
    end
  end
endmodule

// File: rtl/bcast_ld_unit.sv
module bcast_ld_unit
  import bcast_ld_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                idle,
  input  logic [4:0]          base_idx,
  input  logic [63:0]         gpr_val,
  input  logic [63:0]         sp_val,
  input  logic [5:0]          imm_off,
  input  logic [1:0]          esize_sel,
  input  logic [VLEN/8-1:0]   pred,
  input  logic                sp_chk_idle,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [63:0]         mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [7:0]          mem_rsp_data,
  output logic                done,
  output logic [VLEN-1:0]     result,
  output logic                sp_fault
);
  localparam int NCH = VLEN / CHUNK_W;

  ld_state_e        st;
  logic [NCH-1:0]   act_in, low_in, act_q, low_q;
  logic             any_in;
  logic [VLEN-1:0]  fill_vec;
  logic             use_sp, chk_sp, misal;
  logic [63:0]      base;

  bcast_lane_mask #(.VLEN(VLEN)) u_mask (
    .esize_sel (esize_sel),
    .pred      (pred),
    .chunk_act (act_in),
    .chunk_low (low_in),
    .any_act   (any_in)
  );

  bcast_fill #(.VLEN(VLEN)) u_fill (
    .ld_byte   (mem_rsp_data),
    .chunk_act (act_q),
    .chunk_low (low_q),
    .vec       (fill_vec)
  );

  assign use_sp = (base_idx == 5'(SP_IDX));
  assign chk_sp = use_sp && (any_in || sp_chk_idle);
  assign misal  = chk_sp && (sp_val[ALIGN_BITS-1:0] != '0);
  assign base   = use_sp ? sp_val : gpr_val;
  assign idle   = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      act_q         <= '0;
      low_q         <= '0;
      done          <= 1'b0;
      sp_fault      <= 1'b0;
      result        <= '0;
    end else begin
      done     <= 1'b0;
      sp_fault <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          act_q <= act_in;
          low_q <= low_in;
          if (misal || !any_in) begin
            done     <= 1'b1;
            sp_fault <= misal;
            result   <= '0;
          end else begin
            st            <= ST_REQ;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= base + {58'd0, imm_off};
          end
        end
        ST_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          st            <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          result <= fill_vec;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fault_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    sp_fault |-> (!mem_req_valid && done && result == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_skip_when_idle_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (idle && start && !any_in) |=> (done && !mem_req_valid && result == '0));

  assert_rsp_to_done_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && mem_rsp_valid) |=> done);
endmodule

// File: tb/bcast_ld_unit_test.sv
`timescale 1ns/1ps
module bcast_ld_unit_test;
  localparam int VL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic idle;
  logic [4:0]  base_idx = '0;
  logic [63:0] gpr_val = '0, sp_val = '0;
  logic [5:0]  imm_off = '0;
  logic [1:0]  esize_sel = '0;
  logic [7:0]  pred = '0;
  logic        sp_chk_idle = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = '0;
  logic        done, sp_fault;
  logic [VL-1:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bcast_ld_unit #(.VLEN(VL)) uut (
    .clk(clk), .rst(rst), .start(start), .idle(idle),
    .base_idx(base_idx), .gpr_val(gpr_val), .sp_val(sp_val),
    .imm_off(imm_off), .esize_sel(esize_sel), .pred(pred),
    .sp_chk_idle(sp_chk_idle),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .result(result),
    .sp_fault(sp_fault)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] es);
    return (es == 2'd0) ? 16 : (es == 2'd1) ? 32 : 64;
  endfunction

  function automatic logic [63:0] exp_vec(input logic [7:0] b,
                                          input logic [7:0] p,
                                          input logic [1:0] es);
    logic [63:0] v;
    int w;
    w = width_of(es);
    for (int k = 0; k < 64; k++) begin
      int ln = k / w;
      int pos = k % w;
      if (p[ln * w / 8]) v[k] = (pos < 8) ? b[pos] : b[7];
      else v[k] = 1'b0;
    end
    return v;
  endfunction

  function automatic bit any_lane(input logic [7:0] p, input logic [1:0] es);
    bit a;
    int w;
    a = 0;
    w = width_of(es);
    for (int e = 0; e < 64 / w; e++) if (p[e * w / 8]) a = 1;
    return a;
  endfunction

  task automatic run_op(input logic [4:0] idx, input logic [63:0] g,
                        input logic [63:0] s, input logic [5:0] im,
                        input logic [1:0] es, input logic [7:0] pr,
                        input logic ck, input int rdly, input int sdly,
                        input bit poke);
    logic [63:0] ea, ev, lm;
    logic [7:0]  by;
    bit any, usp, flt, req;
    usp = (idx == 5'd31);
    ea  = (usp ? s : g) + {58'd0, im};
    by  = ea[7:0] ^ 8'hA5;
    any = any_lane(pr, es);
    flt = usp && (any || ck) && (s[3:0] != 4'd0);
    req = any && !flt;
    ev  = exp_vec(by, pr, es);
    lm  = exp_vec(8'hFF, pr, es);

    @(negedge clk);
    base_idx = idx; gpr_val = g; sp_val = s; imm_off = im;
    esize_sel = es; pred = pr; sp_chk_idle = ck; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!req) begin
      check(done == 1'b1, flt ? (any ? "R6 done" : "R7 done") : "R5 done", 64'(done), 64'd1);
      check(!mem_req_valid, flt ? "R6 no request" : "R5 no request", 64'(mem_req_valid), 64'd0);
      check(sp_fault == flt, any ? "R6 fault" : "R7 fault", 64'(sp_fault), 64'(flt));
      check(result == '0, "R5 zero result", result, 64'd0);
      @(negedge clk);
      check(!done, "R9 pulse", 64'(done), 64'd0);
    end else begin
      check(mem_req_valid && !done && !idle, "R8 request raised", 64'(mem_req_valid), 64'd1);
      check(mem_req_addr == ea, "R1 address", mem_req_addr, ea);
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        if (poke && k == 0) begin
          pred = ~pr; esize_sel = 2'd0; gpr_val = ~g; sp_val = ~s; start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
      check(mem_req_valid && mem_req_addr == ea, "R8 request held", mem_req_addr, ea);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      check(!mem_req_valid, "R8 request dropped", 64'(mem_req_valid), 64'd0);
      for (int k = 0; k < sdly; k++) begin
        @(negedge clk);
        check(!done, "R9 no early done", 64'(done), 64'd0);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = by;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = 8'h00;
      check(done && !sp_fault, "R9 done after response", 64'(done), 64'd1);
      check(result == ev, "R2/R3 broadcast", result, ev);
      check((result & ~lm) == '0, "R4 inactive zero", result & ~lm, 64'd0);
      @(negedge clk);
      check(!done && idle, poke ? "R9 start ignored while busy" : "R9 pulse", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !mem_req_valid && !sp_fault && idle && result == '0,
          "R9 reset state", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int es = 0; es < 4; es++) begin
      for (int p = 0; p < 256; p++) begin
        run_op(5'(p % 31), {8'(p), 8'(es), 48'h1234_5678_9ABC} ^ 64'(p * 977),
               64'h0, 6'(p), 2'(es), 8'(p), 1'b0, p % 3, (p / 3) % 3, 1'b0);
      end
    end

    run_op(5'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 6'd63, 2'd0, 8'h01, 1'b0, 0, 0, 1'b0);
    run_op(5'd31, 64'h0, 64'h0000_0000_8000_1230, 6'd17, 2'd1, 8'h10, 1'b0, 1, 1, 1'b0);
    run_op(5'd31, 64'h0, 64'h0000_0000_8000_1238, 6'd5, 2'd2, 8'h01, 1'b0, 0, 0, 1'b0);
    run_op(5'd31, 64'h0, 64'h0000_0000_8000_1234, 6'd5, 2'd0, 8'h00, 1'b1, 0, 0, 1'b0);
    run_op(5'd31, 64'h0, 64'h0000_0000_8000_1234, 6'd5, 2'd0, 8'h00, 1'b0, 0, 0, 1'b0);
    run_op(5'd31, 64'h0, 64'h0000_0000_8000_1230, 6'd5, 2'd2, 8'hFE, 1'b1, 0, 0, 1'b0);
    run_op(5'd7, 64'h0000_0000_0000_1000, 64'h1, 6'd9, 2'd0, 8'h55, 1'b1, 3, 2, 1'b1);
    run_op(5'd31, 64'h0, 64'h0000_0000_0000_2000, 6'd40, 2'd1, 8'h11, 1'b0, 2, 0, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule